// File: doc/BRIEF.md
# Signed Vector Element Extract Unit

This block takes one 32-bit instruction word per accepted transfer and carries out the operation "move one signed element of a vector register into a general register". It drives the source vector register number to a 128-bit register-file read port and gets the vector back combinationally in the same cycle. From it the block picks a byte, halfword or word lane, sign-extends that lane to a 32-bit or 64-bit result, and returns a register-file write request one cycle later.

Encodings that are reserved are flagged as undefined and do not write. When a required unit-enable input is low, the block raises a trap and does not write. A destination number of 31 names the zero register, so the write is dropped. Instruction words whose fixed fields do not match are still accepted. They come back with a cleared hit flag and no side effects.

Both edges use valid/ready. An input word is accepted when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. A result that is not taken stays unchanged until `out_ready` is high. The latency is exactly one cycle and does not depend on the data.

Top module: `vext_unit`

## Requirements
- R1: A word is recognised only when bit 31 = 0, bit 29 = 0, bits 28:21 = 8'b01110000, bit 15 = 0, bits 14:11 = 4'b0101 and bit 10 = 1. Any other accepted word returns `out_hit`=0 with `out_wen`, `out_undef`, `out_trap` all 0 and `out_data`=0.
- R2: Bits 9:5 of the word are driven on `vec_addr` in the same cycle. Bits 4:0 of an accepted word appear on `out_dst`. Bit 30 selects the result width: 0 gives 32 bits, 1 gives 64 bits.
- R3: The lane size comes from the lowest set bit of field bits 20:16 (called imm). imm[0]=1 selects a byte with index imm[4:1]. Otherwise imm[1]=1 selects a halfword with index imm[4:2]. Otherwise imm[2]=1 selects a word with index imm[4:3].
- R4: imm[2:0]=000 marks the word undefined. An undefined result has `out_wen`=0, `out_trap`=0 and `out_data`=0.
- R5: A word lane with the 32-bit result width is undefined. A word lane with the 64-bit width is legal.
- R6: The lane is taken from bit offset index times lane width in the 128-bit source. It is sign-extended to the result width. With the 32-bit width, `out_data[63:32]` is zero.
- R7: With index 0 only `fp_en` is required. With a nonzero index both `fp_en` and `vec_en` are required. A missing enable sets `out_trap`=1, `out_wen`=0 and `out_data`=0. An undefined word never traps.
- R8: Destination 31 forces `out_wen`=0. `out_data`, `out_undef` and `out_trap` are unaffected.
- R9: `in_ready` = !`out_valid` || `out_ready`. An accepted word gives `out_valid` on the next cycle. An untaken result holds all output fields stable.
- R10: After reset `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Block can take a word this cycle |
| in_insn | input | 32 | Instruction word |
| fp_en | input | 1 | Floating-point unit enabled |
| vec_en | input | 1 | Vector unit enabled |
| vec_addr | output | 5 | Source vector register number for the read port |
| vec_data | input | 128 | Source vector returned by the read port, same cycle |
| out_valid | output | 1 | Result held |
| out_ready | input | 1 | Consumer takes the result |
| out_hit | output | 1 | Word was recognised |
| out_wen | output | 1 | General register write enable |
| out_dst | output | 5 | Destination register number |
| out_data | output | 64 | Write data |
| out_undef | output | 1 | Undefined encoding |
| out_trap | output | 1 | Enable trap |

## Verification
The assertions assume three things about the inputs. The register-file read port answers combinationally for the address driven in the same cycle. `fp_en` and `vec_en` are only meaningful in the cycle of acceptance. The consumer may hold `out_ready` low for any number of cycles. The bench model meets these assumptions with a bench-side register array indexed directly by `vec_addr`. It changes inputs only away from the clock edge, and it mixes stalled and free-flowing stretches of `out_ready`, so the stability and latency properties are both exercised.

// File: rtl/vext_pkg.sv
package vext_pkg;
  typedef enum logic [1:0] {
    ESZ_B    = 2'd0,
    ESZ_H    = 2'd1,
    ESZ_W    = 2'd2,
    ESZ_NONE = 2'd3
  } esz_t;

  localparam logic [31:0] FIX_MASK = 32'hBFE0_FC00;
  localparam logic [31:0] FIX_VAL  = 32'h0E00_2C00;

  typedef struct packed {
    logic       hit;
    logic       wide;
    logic [4:0] imm;
    esz_t       esz;
    logic       idx_zero;
    logic       undef;
    logic [4:0] src;
    logic [4:0] dst;
  } dec_t;
endpackage

// File: rtl/vext_decode.sv
module vext_decode
  import vext_pkg::*;
(
  input  logic [31:0] insn,
  output dec_t        dec
);
  always_comb begin
    dec.hit  = (insn & FIX_MASK) == FIX_VAL;
    dec.wide = insn[30];
    dec.imm  = insn[20:16];
    dec.src  = insn[9:5];
    dec.dst  = insn[4:0];
    if (dec.imm[0])      dec.esz = ESZ_B;
    else if (dec.imm[1]) dec.esz = ESZ_H;
    else if (dec.imm[2]) dec.esz = ESZ_W;
    else                 dec.esz = ESZ_NONE;
    unique case (dec.esz)
      ESZ_B:   dec.idx_zero = dec.imm[4:1] == 4'd0;
      ESZ_H:   dec.idx_zero = dec.imm[4:2] == 3'd0;
      ESZ_W:   dec.idx_zero = dec.imm[4:3] == 2'd0;
      default: dec.idx_zero = 1'b1;
    endcase
    dec.undef = dec.hit &&
                ((dec.esz == ESZ_NONE) || (dec.esz == ESZ_W && !dec.wide));
  end
endmodule

// File: rtl/vext_select.sv
module vext_select
  import vext_pkg::*;
#(
  parameter int VEC_W = 128,
  parameter int RES_W = 64,
  parameter int NSZ   = 3
) (
  input  logic [VEC_W-1:0] vec,
  input  esz_t             esz,
  input  logic [4:0]       imm,
  input  logic             wide,
  output logic [RES_W-1:0] res
);
  localparam int OFF_W = $clog2(VEC_W);
  localparam int HALF  = RES_W / 2;

  logic [OFF_W-1:0] off;
  logic [VEC_W-1:0] shifted;
  logic [RES_W-1:0] ext [NSZ];

  always_comb begin
    unique case (esz)
      ESZ_B:   off = OFF_W'({imm[4:1], 3'b000});
      ESZ_H:   off = OFF_W'({imm[4:2], 4'b0000});
      ESZ_W:   off = OFF_W'({imm[4:3], 5'b00000});
      default: off = '0;
    endcase
  end

  assign shifted = vec >> off;

  for (genvar g = 0; g < NSZ; g++) begin : g_ext
    localparam int EW = 8 << g;
    assign ext[g] = {{(RES_W-EW){shifted[EW-1]}}, shifted[EW-1:0]};
  end

  logic [RES_W-1:0] full;
  always_comb begin
    unique case (esz)
      ESZ_B:   full = ext[0];
      ESZ_H:   full = ext[1];
      ESZ_W:   full = ext[2];
      default: full = '0;
    endcase
    res = wide ? full : {{HALF{1'b0}}, full[HALF-1:0]};
  end
endmodule

// File: rtl/vext_unit.sv
module vext_unit
  import vext_pkg::*;
#(
  parameter int VEC_W = 128,
  parameter int RES_W = 64,
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [31:0]       in_insn,
  input  logic              fp_en,
  input  logic              vec_en,
  output logic [REG_AW-1:0] vec_addr,
  input  logic [VEC_W-1:0]  vec_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_hit,
  output logic              out_wen,
  output logic [REG_AW-1:0] out_dst,
  output logic [RES_W-1:0]  out_data,
  output logic              out_undef,
  output logic              out_trap
);
  localparam logic [REG_AW-1:0] ZR = '1;

  dec_t             dec;
  logic [RES_W-1:0] res;
  logic             need_ok, trap, ok, accept;

  vext_decode u_dec (.insn(in_insn), .dec(dec));

  vext_select #(.VEC_W(VEC_W), .RES_W(RES_W)) u_sel (
    .vec(vec_data), .esz(dec.esz), .imm(dec.imm), .wide(dec.wide), .res(res)
  );

  assign vec_addr = REG_AW'(dec.src);
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign need_ok  = dec.idx_zero ? fp_en : (fp_en && vec_en);
  assign trap     = dec.hit && !dec.undef && !need_ok;
  assign ok       = dec.hit && !dec.undef && !trap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_hit   <= 1'b0;
      out_wen   <= 1'b0;
      out_dst   <= '0;
      out_data  <= '0;
      out_undef <= 1'b0;
      out_trap  <= 1'b0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_hit   <= dec.hit;
      out_wen   <= ok && (REG_AW'(dec.dst) != ZR);
      out_dst   <= REG_AW'(dec.dst);
      out_data  <= ok ? res : '0;
      out_undef <= dec.undef;
      out_trap  <= trap;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R9
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_wen) && $stable(out_dst)); // R9
  AST_ZERO_REG: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_dst == ZR |-> !out_wen); // R8
  AST_UNDEF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_undef |-> !out_wen && !out_trap && out_data == '0); // R4
  AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_hit |-> !out_wen && !out_undef && !out_trap); // R1
  AST_TRAP_NOWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_trap |-> !out_wen && out_data == '0); // R7
endmodule

// File: tb/vext_unit_tb.sv
`timescale 1ns/1ps
module vext_unit_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [31:0] in_insn = '0;
  logic fp_en = 1'b0, vec_en = 1'b0;
  logic [4:0] vec_addr;
  logic [127:0] vec_data;
  logic out_valid, out_ready = 1'b1, out_hit, out_wen, out_undef, out_trap;
  logic [4:0] out_dst;
  logic [63:0] out_data;

  logic [127:0] vrf [32];
  assign vec_data = vrf[vec_addr];

  always #2.5 clk = ~clk;

  vext_unit u_dut (.*);

  int total = 0, bad = 0;

  logic m_valid = 1'b0, m_hit, m_wen, m_undef, m_trap;
  logic [4:0] m_dst;
  logic [63:0] m_data;

  task automatic chk(input string tag, input string what, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic q, input logic [4:0] imm, input logic [4:0] rn, input logic [4:0] rd);
    return {1'b0, q, 1'b0, 8'b01110000, imm, 1'b0, 4'b0101, 1'b1, rn, rd};
  endfunction

  function automatic void model(input logic [31:0] w, input logic fp, input logic ve);
    int sz, idx, es;
    logic [4:0] imm;
    logic [127:0] sh;
    logic [63:0] v;
    logic need, good;
    imm = w[20:16];
    m_hit = !w[31] && !w[29] && w[28:21] == 8'b01110000 && !w[15] && w[14:11] == 4'b0101 && w[10];
    sz = imm[0] ? 0 : imm[1] ? 1 : imm[2] ? 2 : -1;
    m_undef = m_hit && (sz < 0 || (32 << w[30]) <= (8 << sz));
    idx = (sz < 0) ? 0 : int'(imm) >> (sz + 1);
    es = (sz < 0) ? 8 : (8 << sz);
    sh = vrf[w[9:5]] >> (idx * es);
    v = sh[63:0] & ((64'd1 << es) - 64'd1);
    if (v[es-1]) v = v | ~((64'd1 << es) - 64'd1);
    if (!w[30]) v[63:32] = 32'd0;
    need = (idx == 0) ? fp : (fp && ve);
    m_trap = m_hit && !m_undef && !need;
    good = m_hit && !m_undef && !m_trap;
    m_data = good ? v : 64'd0;
    m_wen = good && w[4:0] != 5'd31;
    m_dst = w[4:0];
  endfunction

  task automatic step(input logic v, input logic [31:0] w, input logic fp, input logic ve,
                      input logic ordy, input string tag);
    logic rdy;
    in_valid = v; in_insn = w; fp_en = fp; vec_en = ve; out_ready = ordy;
    #1;
    rdy = !m_valid || ordy;
    chk("R9", "in_ready", in_ready, rdy);
    if (v) chk("R2", "vec_addr", vec_addr, w[9:5]);
    if (v && rdy) begin
      m_valid = 1'b1;
      model(w, fp, ve);
    end else if (ordy) begin
      m_valid = 1'b0;
    end
    @(negedge clk);
    chk(tag, "out_valid", out_valid, m_valid);
    if (m_valid) begin
      chk(tag, "out_hit", out_hit, m_hit);
      chk(tag, "out_wen", out_wen, m_wen);
      chk(tag, "out_dst", out_dst, m_dst);
      chk(tag, "out_data", out_data, m_data);
      chk(tag, "out_undef", out_undef, m_undef);
      chk(tag, "out_trap", out_trap, m_trap);
    end
  endtask

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) vrf[i] = {$urandom, $urandom, $urandom, $urandom};
    vrf[3] = 128'hF0E1D2C3_B4A59687_78695A4B_3C2D1E0F;
    repeat (3) @(negedge clk);
    chk("R10", "out_valid", out_valid, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", "out_valid", out_valid, 1'b0);
    // R1: fixed-field mismatch
    step(1, mk(1, 5'b00001, 5'd3, 5'd2) & ~32'h400, 1, 1, 1, "R1");
    step(1, mk(1, 5'b00001, 5'd3, 5'd2) | 32'h8000_0000, 1, 1, 1, "R1");
    // R3 / R6 byte, index 0 and 15, both widths
    step(1, mk(0, 5'b00001, 5'd3, 5'd2), 1, 1, 1, "R3");
    step(1, mk(1, 5'b11111, 5'd3, 5'd4), 1, 1, 1, "R6");
    step(1, mk(0, 5'b11111, 5'd3, 5'd4), 1, 1, 1, "R6");
    // R3 halfword index 7, word index 3
    step(1, mk(0, 5'b11110, 5'd3, 5'd5), 1, 1, 1, "R3");
    step(1, mk(1, 5'b11100, 5'd3, 5'd6), 1, 1, 1, "R5");
    step(1, mk(0, 5'b11100, 5'd3, 5'd6), 1, 1, 1, "R5");
    // R4 reserved size
    step(1, mk(1, 5'b10000, 5'd3, 5'd7), 1, 1, 1, "R4");
    step(1, mk(1, 5'b00000, 5'd3, 5'd7), 0, 0, 1, "R4");
    // R7 enables
    step(1, mk(1, 5'b00001, 5'd3, 5'd8), 0, 1, 1, "R7");
    step(1, mk(1, 5'b00001, 5'd3, 5'd8), 1, 0, 1, "R7");
    step(1, mk(1, 5'b00101, 5'd3, 5'd8), 1, 0, 1, "R7");
    step(1, mk(0, 5'b00100, 5'd3, 5'd8), 0, 0, 1, "R7");
    // R8 zero register
    step(1, mk(1, 5'b00011, 5'd3, 5'd31), 1, 1, 1, "R8");
    step(1, mk(1, 5'b00011, 5'd3, 5'd31), 0, 1, 1, "R8");
    // R9 back-pressure
    step(1, mk(1, 5'b01010, 5'd3, 5'd9), 1, 1, 0, "R9");
    step(1, mk(1, 5'b00001, 5'd3, 5'd10), 1, 1, 0, "R9");
    step(0, 32'd0, 1, 1, 0, "R9");
    step(1, mk(1, 5'b00001, 5'd3, 5'd10), 1, 1, 1, "R9");
    step(0, 32'd0, 1, 1, 1, "R9");
    // R6 random sweep
    for (int n = 0; n < 400; n++) begin
      logic [31:0] w;
      w = mk($urandom_range(0, 1), 5'($urandom), 5'($urandom), 5'($urandom));
      if ($urandom_range(0, 9) == 0) w = $urandom;
      step($urandom_range(0, 3) != 0, w, $urandom_range(0, 7) != 0,
           $urandom_range(0, 7) != 0, $urandom_range(0, 3) != 0, "R6");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule